// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two packed operand words in one pass. The carry chain is divided at run time into independent lanes. One operation then works on one full-width lane, two half-width lanes, four quarter-width lanes, or lanes as narrow as a single segment. Every lane does the same operation in the same cycle. No carry or borrow crosses from one lane into the next.

A mode input chooses between two kinds of arithmetic. In wrap-around arithmetic each lane keeps the low bits of its result. In saturating arithmetic a lane that overflows is clamped to the nearest value it can hold. A signedness input chooses two's-complement or unsigned limits for the clamp and for overflow detection. The block reports one overflow flag per segment position. The result and the flags are registered once, so they appear one clock after the inputs.

By default the datapath is 64 bits wide, built from eight 8-bit segments. The two 32-bit halves of the word can therefore be handled as a packed pair.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel` = k gives lanes of `SEG_W << k` bits, aligned to multiples of that width. Codes above `log2(NSEG)` give one lane that spans the whole word.
- R2: No carry or borrow crosses a lane boundary, in any lane width, in either operation.
- R3: With `sub_en`=1 each lane computes `op_a - op_b` on its own bits, in two's complement. This works by inverting B and injecting a carry of 1 at the lane's lowest bit.
- R4: With `sat_en`=0 each lane result is the true sum or difference taken modulo 2^(lane width).
- R5: With `sat_en`=1 and `signed_en`=0, an add that exceeds the lane range gives all-ones in that lane, and a subtract that goes below zero gives all-zeros.
- R6: With `sat_en`=1 and `signed_en`=1, a lane whose true result is above the maximum gives 0 followed by all ones (the maximum positive value). A lane whose true result is below the minimum gives 1 followed by all zeros (the minimum negative value).
- R7: `ovf_flags` has one bit per segment. Bit i covers bits `[i*SEG_W +: SEG_W]`. A lane's flag sits in the bit of its highest segment, and all other bits are 0. In signed mode the flag means the true result falls outside the two's-complement range. In unsigned mode it means a carry-out on an add or a borrow on a subtract. The flag is the same in wrap and saturating modes.
- R8: `result` and `ovf_flags` change only at a rising clock edge. They show the function of the inputs sampled at that edge.
- R9: A synchronous active-high `rst` clears `result` and `ovf_flags` to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_sel | input | LSEL_W | Lane-width code (R1) |
| sub_en | input | 1 | 1 = subtract B from A, 0 = add |
| sat_en | input | 1 | 1 = saturating, 0 = wrap-around |
| signed_en | input | 1 | 1 = two's-complement limits, 0 = unsigned |
| op_a | input | SEG_W*NSEG | Packed operand A |
| op_b | input | SEG_W*NSEG | Packed operand B |
| result | output | SEG_W*NSEG | Registered packed result |
| ovf_flags | output | NSEG | Registered per-segment overflow flags (R7) |

## Verification
The bench builds the block with `SEG_W`=4 and `NSEG`=4. This gives a 16-bit word with 4-, 8- and 16-bit lanes, plus one out-of-range lane code. With nibble lanes, overflow, clamping in both directions and carries at every boundary occur in most vectors. Every lane code is crossed with every combination of add/subtract, wrap/saturate and signed/unsigned. Each combination runs a full grid of edge operands (zero, all-ones, the signed extremes and mixed patterns) plus pseudo-random pairs. Each vector is compared against lane arithmetic that the bench computes with wide integers.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  // Clamp a lane-width code to the widest legal code.
  function automatic int eff_lane_code(input int code, input int max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // Overflow rule. The signed rule compares the carry into and out of the top bit.
  // The unsigned rule is the carry-out for an add and a missing carry (a borrow) for a subtract.
  function automatic logic lane_ovf(input logic signed_mode, input logic is_sub,
                                    input logic c_into_msb, input logic c_out);
    return signed_mode ? (c_into_msb ^ c_out) : (c_out ^ is_sub);
  endfunction

endpackage

// File: rtl/lane_bound_dec.sv
module lane_bound_dec #(
  parameter int NSEG   = 8,
  parameter int LSEL_W = 2
) (
  input  logic [LSEL_W-1:0] lane_sel,
  output logic [NSEG-1:0]   lsb_mask,
  output logic [NSEG-1:0]   msb_mask
);
  import simd_add_pkg::*;

  localparam int MAXCODE = $clog2(NSEG);

  int code_eff;
  int span;

  always_comb begin
    code_eff = eff_lane_code(int'(lane_sel), MAXCODE);
    span     = 1 << code_eff;
    for (int s = 0; s < NSEG; s++) begin
      lsb_mask[s] = ((s & (span - 1)) == 0);
      msb_mask[s] = ((s & (span - 1)) == (span - 1));
    end
  end
endmodule

// File: rtl/simd_seg_chain.sv
module simd_seg_chain #(
  parameter int SEG_W = 8,
  parameter int NSEG  = 8
) (
  input  logic [SEG_W*NSEG-1:0] op_a,
  input  logic [SEG_W*NSEG-1:0] op_b,
  input  logic                  sub_en,
  input  logic [NSEG-1:0]       lsb_mask,
  output logic [SEG_W*NSEG-1:0] raw_sum,
  output logic [NSEG-1:0]       c_out,
  output logic [NSEG-1:0]       c_msb
);
  logic [SEG_W-1:0] a_seg;
  logic [SEG_W-1:0] b_seg;
  logic [SEG_W-1:0] low;
  logic [1:0]       top;
  logic             cin;
  logic             carry;

  // The segment's carry-in is either the lane injection (at a lane's low segment) or the carry from the segment below.
  always_comb begin
    carry = sub_en;
    for (int s = 0; s < NSEG; s++) begin
      a_seg = op_a[s*SEG_W +: SEG_W];
      b_seg = op_b[s*SEG_W +: SEG_W] ^ {SEG_W{sub_en}};
      cin   = lsb_mask[s] ? sub_en : carry;
      low   = {1'b0, a_seg[SEG_W-2:0]} + {1'b0, b_seg[SEG_W-2:0]}
            + {{(SEG_W-1){1'b0}}, cin};
      top   = {1'b0, a_seg[SEG_W-1]} + {1'b0, b_seg[SEG_W-1]} + {1'b0, low[SEG_W-1]};
      raw_sum[s*SEG_W +: SEG_W] = {top[0], low[SEG_W-2:0]};
      c_msb[s] = low[SEG_W-1];
      c_out[s] = top[1];
      carry    = top[1];
    end
  end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat #(
  parameter int SEG_W = 8,
  parameter int NSEG  = 8
) (
  input  logic [SEG_W*NSEG-1:0] raw_sum,
  input  logic [SEG_W*NSEG-1:0] op_a,
  input  logic [NSEG-1:0]       c_out,
  input  logic [NSEG-1:0]       c_msb,
  input  logic [NSEG-1:0]       msb_mask,
  input  logic                  sub_en,
  input  logic                  sat_en,
  input  logic                  signed_en,
  output logic [SEG_W*NSEG-1:0] lane_res,
  output logic [NSEG-1:0]       lane_flag
);
  import simd_add_pkg::*;

  logic ov;
  logic neg;

  // Walk from the top segment down. Each lane's top segment decides the lane's overflow
  // and clamp direction, and the segments below it in the lane take the same values.
  always_comb begin
    ov  = 1'b0;
    neg = 1'b0;
    for (int s = NSEG - 1; s >= 0; s--) begin
      if (msb_mask[s]) begin
        ov  = lane_ovf(signed_en, sub_en, c_msb[s], c_out[s]);
        neg = op_a[s*SEG_W + SEG_W - 1];
      end
      lane_flag[s] = msb_mask[s] & ov;
      if (sat_en && ov) begin
        if (signed_en)
          lane_res[s*SEG_W +: SEG_W] = msb_mask[s] ? {neg, {(SEG_W-1){~neg}}}
                                                   : {SEG_W{~neg}};
        else
          lane_res[s*SEG_W +: SEG_W] = {SEG_W{~sub_en}};
      end else begin
        lane_res[s*SEG_W +: SEG_W] = raw_sum[s*SEG_W +: SEG_W];
      end
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int SEG_W  = 8,
  parameter int NSEG   = 8,
  parameter int LSEL_W = $clog2($clog2(NSEG) + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LSEL_W-1:0]     lane_sel,
  input  logic                  sub_en,
  input  logic                  sat_en,
  input  logic                  signed_en,
  input  logic [SEG_W*NSEG-1:0] op_a,
  input  logic [SEG_W*NSEG-1:0] op_b,
  output logic [SEG_W*NSEG-1:0] result,
  output logic [NSEG-1:0]       ovf_flags
);
  localparam int DATA_W  = SEG_W * NSEG;
  localparam int MAXCODE = $clog2(NSEG);

  logic [NSEG-1:0]   lsb_mask;
  logic [NSEG-1:0]   msb_mask;
  logic [DATA_W-1:0] raw_sum;
  logic [NSEG-1:0]   c_out;
  logic [NSEG-1:0]   c_msb;
  logic [DATA_W-1:0] lane_res;
  logic [NSEG-1:0]   lane_flag;

  lane_bound_dec #(.NSEG(NSEG), .LSEL_W(LSEL_W)) u_dec (
    .lane_sel (lane_sel),
    .lsb_mask (lsb_mask),
    .msb_mask (msb_mask)
  );

  simd_seg_chain #(.SEG_W(SEG_W), .NSEG(NSEG)) u_chain (
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_en   (sub_en),
    .lsb_mask (lsb_mask),
    .raw_sum  (raw_sum),
    .c_out    (c_out),
    .c_msb    (c_msb)
  );

  simd_lane_sat #(.SEG_W(SEG_W), .NSEG(NSEG)) u_sat (
    .raw_sum   (raw_sum),
    .op_a      (op_a),
    .c_out     (c_out),
    .c_msb     (c_msb),
    .msb_mask  (msb_mask),
    .sub_en    (sub_en),
    .sat_en    (sat_en),
    .signed_en (signed_en),
    .lane_res  (lane_res),
    .lane_flag (lane_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      ovf_flags <= '0;
    end else begin
      result    <= lane_res;
      ovf_flags <= lane_flag;
    end
  end

  // R9: the outputs are clear one edge after reset.
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (result == '0 && ovf_flags == '0));

  // R4 and R8: a full-width wrapping add equals the plain modular sum of the inputs from the previous edge.
  p_wrap_full_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sat_en) && !$past(sub_en) &&
     $past(lane_sel) >= LSEL_W'(MAXCODE))
    |-> result == $past(op_a) + $past(op_b));

  // R7: with a single lane, only the top flag bit can be set.
  p_flag_top_only_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lane_sel) >= LSEL_W'(MAXCODE))
    |-> ovf_flags[NSEG-2:0] == '0);

  // R5: an unsigned saturating add that overflows gives all ones.
  p_usat_add_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sat_en) && !$past(signed_en) && !$past(sub_en) &&
     $past(lane_sel) >= LSEL_W'(MAXCODE) && ovf_flags[NSEG-1])
    |-> result == {DATA_W{1'b1}});

  // R5: an unsigned saturating subtract that borrows gives zero.
  p_usat_sub_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sat_en) && !$past(signed_en) && $past(sub_en) &&
     $past(lane_sel) >= LSEL_W'(MAXCODE) && ovf_flags[NSEG-1])
    |-> result == '0);

  // R6: a signed clamp takes the sign of A and fills the bits below with its inverse.
  p_ssat_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sat_en) && $past(signed_en) &&
     $past(lane_sel) >= LSEL_W'(MAXCODE) && ovf_flags[NSEG-1])
    |-> (result[DATA_W-1] == $past(op_a[DATA_W-1]) &&
         result[DATA_W-2] != $past(op_a[DATA_W-1])));
endmodule

// File: tb/simd_sat_adder_bench.sv
`timescale 1ns/1ps
module simd_sat_adder_bench;
  localparam int SEG_W  = 4;
  localparam int NSEG   = 4;
  localparam int DATA_W = SEG_W * NSEG;
  localparam int LSEL_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LSEL_W-1:0] lane_sel = '0;
  logic              sub_en = 1'b0, sat_en = 1'b0, signed_en = 1'b0;
  logic [DATA_W-1:0] op_a = '0, op_b = '0;
  logic [DATA_W-1:0] result;
  logic [NSEG-1:0]   ovf_flags;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  simd_sat_adder #(.SEG_W(SEG_W), .NSEG(NSEG), .LSEL_W(LSEL_W)) u_simd_sat_adder (
    .clk(clk), .rst(rst), .lane_sel(lane_sel), .sub_en(sub_en), .sat_en(sat_en),
    .signed_en(signed_en), .op_a(op_a), .op_b(op_b), .result(result), .ovf_flags(ovf_flags)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent lane model using wide integers.
  task automatic model(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input int lsel,
                       input bit sb, input bit st, input bit sg,
                       output logic [DATA_W-1:0] r, output logic [NSEG-1:0] f);
    int code = (lsel > 2) ? 2 : lsel;
    int w    = SEG_W << code;
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    r = '0;
    f = '0;
    for (int l = 0; l < DATA_W / w; l++) begin
      longint ua = (longint'(a) >> (l * w)) & mask;
      longint ub = (longint'(b) >> (l * w)) & mask;
      longint t, v;
      bit ov;
      if (sg) begin
        longint sa = (ua >= half) ? ua - (mask + 1) : ua;
        longint sbv = (ub >= half) ? ub - (mask + 1) : ub;
        t  = sb ? sa - sbv : sa + sbv;
        ov = (t > half - 1) || (t < -half);
        v  = (st && ov) ? ((t > 0) ? half - 1 : -half) : t;
      end else begin
        t  = sb ? ua - ub : ua + ub;
        ov = (t < 0) || (t > mask);
        v  = (st && ov) ? ((t < 0) ? 0 : mask) : t;
      end
      r = r | DATA_W'((v & mask) << (l * w));
      f[(l * w) / SEG_W + w / SEG_W - 1] = ov;
    end
  endtask

  task automatic drive(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input int lsel,
                       input bit sb, input bit st, input bit sg);
    op_a = a; op_b = b; lane_sel = LSEL_W'(lsel);
    sub_en = sb; sat_en = st; signed_en = sg;
  endtask

  task automatic run_vec(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input int lsel,
                         input bit sb, input bit st, input bit sg);
    logic [DATA_W-1:0] er;
    logic [NSEG-1:0]   ef;
    string tag;
    model(a, b, lsel, sb, st, sg, er, ef);
    drive(a, b, lsel, sb, st, sg);
    @(negedge clk);
    tag = st ? (sg ? "R6" : "R5") : (sb ? "R3" : "R4");
    check(result == er, tag, result, er);
    check(ovf_flags == ef, "R7", ovf_flags, ef);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] sp [8];
    logic [31:0] seed;
    sp[0] = 16'h0000; sp[1] = 16'hFFFF; sp[2] = 16'h7FFF; sp[3] = 16'h8000;
    sp[4] = 16'h0001; sp[5] = 16'h7F7F; sp[6] = 16'h8888; sp[7] = 16'h7777;
    seed = 32'h1234_5678;

    drive(16'hABCD, 16'h1234, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R9: reset state
    check(result == '0, "R9", result, 0);
    check(ovf_flags == '0, "R9", ovf_flags, 0);
    rst = 1'b0;

    // R2: a carry out of segment 0 must not reach segment 1 (4-bit lanes, code 0)
    run_vec(16'h000F, 16'h0001, 0, 0, 0, 0);
    check(result == 16'h0000, "R2", result, 16'h0000);
    // R2: a borrow must not cross an 8-bit lane boundary (code 1)
    run_vec(16'h0100, 16'h0001, 1, 1, 0, 0);
    check(result == 16'h01FF, "R2", result, 16'h01FF);
    // R1: the out-of-range code 3 gives one full-width lane
    run_vec(16'h00FF, 16'h0001, 3, 0, 0, 0);
    check(result == 16'h0100, "R1", result, 16'h0100);
    check(ovf_flags == 4'b0000, "R1", ovf_flags, 0);

    // R8: new inputs do not reach the outputs before the next rising edge
    drive(16'h1111, 16'h2222, 2, 0, 0, 0);
    #1;
    check(result == 16'h0100, "R8", result, 16'h0100);
    @(negedge clk);
    check(result == 16'h3333, "R8", result, 16'h3333);

    // R9: reset in the middle of the run
    rst = 1'b1;
    @(negedge clk);
    check(result == '0 && ovf_flags == '0, "R9", result, 0);
    rst = 1'b0;

    // Sweep: every lane code crossed with every mode combination
    for (int lsel = 0; lsel < 4; lsel++) begin
      for (int m = 0; m < 8; m++) begin
        for (int i = 0; i < 320; i++) begin
          logic [DATA_W-1:0] a, b;
          if (i < 64) begin
            a = sp[i / 8];
            b = sp[i % 8];
          end else begin
            seed = seed * 32'd1103515245 + 32'd12345;
            a = seed[30:15];
            seed = seed * 32'd1103515245 + 32'd12345;
            b = seed[30:15];
          end
          run_vec(a, b, lsel, m[0], m[1], m[2]);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule